// File: doc/BRIEF.md
# Coherent Private Cache Controller with Atomic Operations

This block is the private cache of one core that sits on a shared snooping bus beside other caches. It keeps a small direct-mapped array of one-word lines and tracks every line with the four coherence states: Modified, Exclusive, Shared and Invalid. Toward the core it takes one request at a time and returns one response. The request is a plain load, a plain store, a compare-and-swap, or a locked add or decrement. Toward the bus it issues read, read-for-ownership, ownership-upgrade and writeback transactions. It answers snoops from the other caches and supplies dirty data when asked. A simple word memory sits behind the bus inside the block.

Ownership is gained in the cheapest way the line state allows. A line held Shared is upgraded by a data-less invalidate. A locked operation that misses fetches the line straight into Exclusive. While a request is being worked on, only its own line is shielded from snoops. Snoops to every other line are still answered, except while the controller itself owns the bus.

The controller is a single state machine. Its states are IDLE, CHECK, EVICT, FETCH, UPGR, EXEC and RESP, and it moves between them as follows:
- IDLE→CHECK when a request is accepted.
- CHECK→EXEC on a hit that needs nothing more.
- CHECK→UPGR on a hit in Shared by an operation that needs ownership.
- CHECK→EVICT on a miss whose victim is Modified.
- CHECK→FETCH on any other miss.
- EVICT→FETCH, FETCH→EXEC and UPGR→EXEC after the memory latency.
- EXEC→RESP after one cycle for a plain operation, or after the lock window for an atomic.
- RESP→IDLE.

Top module: `mesi_atomic_cache`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, bus_cmd is 0 (idle), snp_ack is 0 and every line is Invalid. After reset, the memory word at address a holds 0x10000000 + 257·a.
- R2: A load that misses issues exactly one bus read (bus_cmd 1). It installs the line in Shared and returns the memory word.
- R3: A load that hits a line in Shared, Exclusive or Modified returns the cached word and issues no bus command.
- R4: A store responds with data 0 and leaves the line Modified. A hit in Exclusive or Modified issues no bus command. A hit in Shared issues one upgrade (bus_cmd 3). A miss issues one read-for-ownership (bus_cmd 2). Stores are never written through.
- R5: A compare-and-swap, add or decrement on a line held Shared issues exactly one upgrade (bus_cmd 3) and no data fetch.
- R6: A compare-and-swap, add or decrement on a line held Exclusive or Modified issues no bus command.
- R7: An atomic operation that misses issues exactly one read-for-ownership (bus_cmd 2) and no read. The line is installed Exclusive, so a failed compare-and-swap leaves it clean.
- R8: The op codes are load 0, store 1, compare-and-swap 2, add 3 and decrement 4. A compare-and-swap whose compare value equals the old word writes the new word, returns the old word with rsp_fail 0, and leaves the line Modified. Otherwise it returns the old word with rsp_fail 1 and changes neither the data nor the state.
- R9: Add writes old + operand, and decrement writes old − 1. Both return the old word and leave the line Modified.
- R10: A miss whose victim line is Modified first issues one writeback (bus_cmd 4) of the victim word to memory, and then the fetch. A Shared or Exclusive victim is dropped with no bus command.
- R11: A snoop (snp_inv 0 for read, 1 for ownership) that hits a Modified line acknowledges with snp_dirty 1 and the cached word, and writes it to memory. A hit on any line moves it to Shared for a read snoop or to Invalid for an ownership snoop. A clean hit or a miss acknowledges with snp_dirty 0.
- R12: A snoop to the line of the request in progress is not acknowledged before that request's response. A snoop to another line is acknowledged during an atomic's lock window. No snoop is acknowledged while the controller's own bus transaction is open.
- R13: Only one request is in flight. req_ready stays 0 from the cycle after acceptance up to and including the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Controller idle; request accepted when both are high |
| req_op | input | 3 | Operation code (see R8) |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data, swap value or add operand |
| req_cmp | input | DATA_W | Compare value for compare-and-swap |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | DATA_W | Loaded or old word; 0 for stores |
| rsp_fail | output | 1 | Compare-and-swap mismatch, valid with rsp_valid |
| bus_cmd | output | 3 | Own bus command, one-cycle pulse: 1 read, 2 read-for-ownership, 3 upgrade, 4 writeback |
| bus_addr | output | ADDR_W | Address of the bus command |
| snp_valid | input | 1 | Snoop from another cache, held until acknowledged |
| snp_inv | input | 1 | 1 for ownership snoop, 0 for read snoop |
| snp_addr | input | ADDR_W | Snooped word address |
| snp_ack | output | 1 | Snoop taken at this clock edge |
| snp_dirty | output | 1 | Snooped line was Modified; snp_data carries it |
| snp_data | output | DATA_W | Supplied word when snp_dirty is 1, else 0 |

## Verification
The assertions assume that the core holds req_valid and its fields stable until acceptance. They also assume that a snoop stays asserted with a fixed address until snp_ack, and that no other agent writes the memory. The bench keeps to these assumptions. Its driver waits for req_ready and then drops req_valid after one accepting edge. It holds each snoop until the acknowledge has been seen, and releases it right after the edge that takes it. The bench never sends a second request before the scoreboard has matched the previous response.

// File: rtl/mesi_pkg.sv
`timescale 1ns/1ps
package mesi_pkg;
    typedef enum logic [1:0] {
        LS_I = 2'd0,
        LS_S = 2'd1,
        LS_E = 2'd2,
        LS_M = 2'd3
    } line_st_t;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_CAS   = 3'd2,
        OP_ADD   = 3'd3,
        OP_DEC   = 3'd4
    } core_op_t;

    typedef enum logic [2:0] {
        BC_IDLE  = 3'd0,
        BC_READ  = 3'd1,
        BC_RFO   = 3'd2,
        BC_UPGR  = 3'd3,
        BC_WBACK = 3'd4
    } bus_cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_EVICT,
        ST_FETCH,
        ST_UPGR,
        ST_EXEC,
        ST_RESP
    } ctl_state_t;
endpackage

// File: rtl/mesi_mem_model.sv
`timescale 1ns/1ps
module mesi_mem_model #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] words [WORDS];

    // Reset image: base plus 257 times the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                words[i] <= DATA_W'(32'h1000_0000) + DATA_W'(i) * DATA_W'(257);
            end
        end else if (wr_en) begin
            words[wr_addr] <= wr_data;
        end
    end

    assign rd_data = words[rd_addr];
endmodule

// File: rtl/mesi_line_store.sv
`timescale 1ns/1ps
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    // core-side port
    input  logic [IDX_W-1:0]  c_idx,
    output line_st_t          c_st,
    output logic [TAG_W-1:0]  c_tag,
    output logic [DATA_W-1:0] c_data,
    input  logic              c_we,
    input  line_st_t          c_wst,
    input  logic [TAG_W-1:0]  c_wtag,
    input  logic [DATA_W-1:0] c_wdata,
    // snoop-side port
    input  logic [IDX_W-1:0]  s_idx,
    output line_st_t          s_st,
    output logic [TAG_W-1:0]  s_tag,
    output logic [DATA_W-1:0] s_data,
    input  logic              s_we,
    input  line_st_t          s_wst
);
    line_st_t          st_arr  [LINES];
    logic [TAG_W-1:0]  tag_arr [LINES];
    logic [DATA_W-1:0] dat_arr [LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                st_arr[i]  <= LS_I;
                tag_arr[i] <= '0;
                dat_arr[i] <= '0;
            end
        end else begin
            if (s_we && !(c_we && (c_idx == s_idx))) begin
                st_arr[s_idx] <= s_wst;
            end
            if (c_we) begin
                st_arr[c_idx]  <= c_wst;
                tag_arr[c_idx] <= c_wtag;
                dat_arr[c_idx] <= c_wdata;
            end
        end
    end

    assign c_st   = st_arr[c_idx];
    assign c_tag  = tag_arr[c_idx];
    assign c_data = dat_arr[c_idx];
    assign s_st   = st_arr[s_idx];
    assign s_tag  = tag_arr[s_idx];
    assign s_data = dat_arr[s_idx];
endmodule

// File: rtl/mesi_snoop_unit.sv
`timescale 1ns/1ps
module mesi_snoop_unit
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 32,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              snp_valid,
    input  logic              snp_inv,
    input  logic [ADDR_W-1:0] snp_addr,
    input  line_st_t          l_st,
    input  logic [TAG_W-1:0]  l_tag,
    input  logic [DATA_W-1:0] l_data,
    input  logic              bus_busy,
    input  logic              lock_act,
    input  logic [IDX_W-1:0]  lock_idx,
    output logic              snp_ack,
    output logic              snp_dirty,
    output logic [DATA_W-1:0] snp_data,
    output logic              s_we,
    output line_st_t          s_wst,
    output logic              m_we,
    output logic [DATA_W-1:0] m_data
);
    logic [IDX_W-1:0] s_idx;
    logic [TAG_W-1:0] s_tag;
    logic             stall;
    logic             present;

    always_comb begin
        s_idx     = snp_addr[IDX_W-1:0];
        s_tag     = snp_addr[ADDR_W-1:IDX_W];
        stall     = bus_busy || (lock_act && (s_idx == lock_idx));
        present   = (l_st != LS_I) && (l_tag == s_tag);
        snp_ack   = snp_valid && !stall;
        snp_dirty = snp_ack && present && (l_st == LS_M);
        snp_data  = snp_dirty ? l_data : '0;
        s_we      = snp_ack && present;
        s_wst     = snp_inv ? LS_I : LS_S;
        m_we      = snp_dirty;
        m_data    = l_data;
    end
endmodule

// File: rtl/mesi_atomic_alu.sv
`timescale 1ns/1ps
module mesi_atomic_alu
    import mesi_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  core_op_t          op,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] cmp_val,
    output logic [DATA_W-1:0] new_val,
    output logic              cas_fail
);
    always_comb begin
        cas_fail = 1'b0;
        new_val  = old_val;
        unique case (op)
            OP_STORE: new_val = operand;
            OP_CAS: begin
                if (old_val == cmp_val) new_val = operand;
                else                    cas_fail = 1'b1;
            end
            OP_ADD:  new_val = old_val + operand;
            OP_DEC:  new_val = old_val - DATA_W'(1);
            default: new_val = old_val;
        endcase
    end
endmodule

// File: rtl/mesi_atomic_cache.sv
`timescale 1ns/1ps
module mesi_atomic_cache
    import mesi_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int LINES    = 4,
    parameter int MEM_LAT  = 3,
    parameter int LOCK_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] req_cmp,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_fail,
    output logic [2:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              snp_valid,
    input  logic              snp_inv,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_ack,
    output logic              snp_dirty,
    output logic [DATA_W-1:0] snp_data
);
    localparam int IDX_W   = $clog2(LINES);
    localparam int TAG_W   = ADDR_W - IDX_W;
    localparam int CNT_MAX = (MEM_LAT > LOCK_CYC) ? MEM_LAT : LOCK_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    ctl_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    core_op_t          op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wd_q, cmp_q, rsp_data_q;
    logic              rsp_fail_q;

    logic [IDX_W-1:0]  idx_q;
    logic [TAG_W-1:0]  tag_q;
    line_st_t          l_st, s_st, c_wst, s_wst;
    logic [TAG_W-1:0]  l_tag, s_tag, c_wtag;
    logic [DATA_W-1:0] l_data, s_data, c_wdata, mem_rdata;
    logic              c_we, s_we, snp_mwe;
    logic [DATA_W-1:0] snp_mdata;
    logic              hit, is_atom, need_own, lat_done, exec_last;
    logic [DATA_W-1:0] alu_new;
    logic              alu_fail;
    logic              bus_busy, lock_act;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata;

    assign idx_q     = addr_q[IDX_W-1:0];
    assign tag_q     = addr_q[ADDR_W-1:IDX_W];
    assign hit       = (l_st != LS_I) && (l_tag == tag_q);
    assign is_atom   = (op_q == OP_CAS) || (op_q == OP_ADD) || (op_q == OP_DEC);
    assign need_own  = (op_q != OP_LOAD);
    assign lat_done  = (cnt_q == CNT_W'(MEM_LAT - 1));
    assign exec_last = is_atom ? (cnt_q == CNT_W'(LOCK_CYC - 1)) : 1'b1;

    mesi_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .c_idx(idx_q), .c_st(l_st), .c_tag(l_tag), .c_data(l_data),
        .c_we(c_we), .c_wst(c_wst), .c_wtag(c_wtag), .c_wdata(c_wdata),
        .s_idx(snp_addr[IDX_W-1:0]), .s_st(s_st), .s_tag(s_tag), .s_data(s_data),
        .s_we(s_we), .s_wst(s_wst)
    );

    mesi_snoop_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_snoop (
        .snp_valid(snp_valid), .snp_inv(snp_inv), .snp_addr(snp_addr),
        .l_st(s_st), .l_tag(s_tag), .l_data(s_data),
        .bus_busy(bus_busy), .lock_act(lock_act), .lock_idx(idx_q),
        .snp_ack(snp_ack), .snp_dirty(snp_dirty), .snp_data(snp_data),
        .s_we(s_we), .s_wst(s_wst), .m_we(snp_mwe), .m_data(snp_mdata)
    );

    mesi_atomic_alu #(.DATA_W(DATA_W)) u_alu (
        .op(op_q), .old_val(l_data), .operand(wd_q), .cmp_val(cmp_q),
        .new_val(alu_new), .cas_fail(alu_fail)
    );

    mesi_mem_model #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(addr_q), .rd_data(mem_rdata),
        .wr_en(mem_we), .wr_addr(mem_waddr), .wr_data(mem_wdata)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_d != state_q) ? '0 : cnt_q + CNT_W'(1);
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_CHECK;
            ST_CHECK: begin
                if (hit) state_d = (need_own && (l_st == LS_S)) ? ST_UPGR : ST_EXEC;
                else     state_d = (l_st == LS_M) ? ST_EVICT : ST_FETCH;
            end
            ST_EVICT: if (lat_done) state_d = ST_FETCH;
            ST_FETCH: if (lat_done) state_d = ST_EXEC;
            ST_UPGR:  if (lat_done) state_d = ST_EXEC;
            ST_EXEC:  if (exec_last) state_d = ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs and array / memory write controls
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_fail  = 1'b0;
        bus_cmd   = BC_IDLE;
        bus_addr  = '0;
        bus_busy  = 1'b0;
        lock_act  = 1'b0;
        c_we      = 1'b0;
        c_wst     = LS_I;
        c_wtag    = tag_q;
        c_wdata   = l_data;
        mem_we    = snp_mwe;
        mem_waddr = snp_addr;
        mem_wdata = snp_mdata;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_CHECK: lock_act = 1'b1;
            ST_EVICT: begin
                bus_busy = 1'b1;
                if (cnt_q == '0) begin
                    bus_cmd   = BC_WBACK;
                    bus_addr  = {l_tag, idx_q};
                    mem_we    = 1'b1;
                    mem_waddr = {l_tag, idx_q};
                    mem_wdata = l_data;
                end
            end
            ST_FETCH: begin
                bus_busy = 1'b1;
                if (cnt_q == '0) begin
                    bus_cmd  = (op_q == OP_LOAD) ? BC_READ : BC_RFO;
                    bus_addr = addr_q;
                end
                if (lat_done) begin
                    c_we    = 1'b1;
                    c_wst   = (op_q == OP_LOAD) ? LS_S : LS_E;
                    c_wdata = mem_rdata;
                end
            end
            ST_UPGR: begin
                bus_busy = 1'b1;
                if (cnt_q == '0) begin
                    bus_cmd  = BC_UPGR;
                    bus_addr = addr_q;
                end
                if (lat_done) begin
                    c_we  = 1'b1;
                    c_wst = LS_E;
                end
            end
            ST_EXEC: begin
                lock_act = 1'b1;
                if (exec_last && need_own && !alu_fail) begin
                    c_we    = 1'b1;
                    c_wst   = LS_M;
                    c_wdata = alu_new;
                end
            end
            ST_RESP: begin
                rsp_valid = 1'b1;
                rsp_fail  = rsp_fail_q;
            end
            default: req_ready = 1'b0;
        endcase
    end

    assign rsp_data = rsp_data_q;

    // Request and response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q       <= OP_LOAD;
            addr_q     <= '0;
            wd_q       <= '0;
            cmp_q      <= '0;
            rsp_data_q <= '0;
            rsp_fail_q <= 1'b0;
        end else begin
            if ((state_q == ST_IDLE) && req_valid) begin
                op_q   <= core_op_t'(req_op);
                addr_q <= req_addr;
                wd_q   <= req_wdata;
                cmp_q  <= req_cmp;
            end
            if ((state_q == ST_EXEC) && exec_last) begin
                rsp_data_q <= (op_q == OP_STORE) ? '0 : l_data;
                rsp_fail_q <= alu_fail;
            end
        end
    end
endmodule

// File: rtl/mesi_atomic_cache_chk.sv
`timescale 1ns/1ps
module mesi_atomic_cache_chk #(
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic [2:0]       bus_cmd,
    input logic             snp_ack,
    input logic             snp_dirty,
    input logic [IDX_W-1:0] snp_idx,
    input logic             lock_act,
    input logic [IDX_W-1:0] lock_idx,
    input logic             bus_busy
);
    // R13
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R13
    ready_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (req_ready && !rsp_valid));

    // R13
    bus_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd != 3'd0) |-> !req_ready);

    // R12
    lock_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_ack |-> !(lock_act && (snp_idx == lock_idx)));

    // R12
    bus_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_ack |-> !bus_busy);

    // R11
    dirty_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_dirty |-> snp_ack);
endmodule

bind mesi_atomic_cache mesi_atomic_cache_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .bus_cmd(bus_cmd), .snp_ack(snp_ack), .snp_dirty(snp_dirty),
    .snp_idx(snp_addr[IDX_W-1:0]), .lock_act(lock_act),
    .lock_idx(addr_q[IDX_W-1:0]), .bus_busy(bus_busy)
);

// File: tb/mesi_atomic_cache_bench.sv
`timescale 1ns/1ps
module mesi_atomic_cache_bench;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int NL = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [2:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0, req_cmp = '0;
    logic          rsp_valid, rsp_fail;
    logic [DW-1:0] rsp_data;
    logic [2:0]    bus_cmd;
    logic [AW-1:0] bus_addr;
    logic          snp_valid = 1'b0, snp_inv = 1'b0;
    logic [AW-1:0] snp_addr = '0;
    logic          snp_ack, snp_dirty;
    logic [DW-1:0] snp_data;

    mesi_atomic_cache u_mesi_atomic_cache (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_cmp(req_cmp),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_fail(rsp_fail),
        .bus_cmd(bus_cmd), .bus_addr(bus_addr), .snp_valid(snp_valid), .snp_inv(snp_inv),
        .snp_addr(snp_addr), .snp_ack(snp_ack), .snp_dirty(snp_dirty), .snp_data(snp_data)
    );

    always #10 clk = ~clk;

    typedef struct {
        string         rq;
        logic [DW-1:0] data;
        logic          fail;
        logic [31:0]   bus;
    } exp_t;

    exp_t          sb[$];
    int            n_checks = 0, n_fail = 0, cyc = 0;
    int            rsp_cyc = 0, ack_cyc = 0;
    logic [7:0]    cnt_rd = 0, cnt_rfo = 0, cnt_upg = 0, cnt_wb = 0;
    int            m_st [NL];
    int            m_tg [NL];
    logic [DW-1:0] m_dt [NL];
    logic [DW-1:0] m_mem [256];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Monitor: count bus commands, pop and compare at each response
    always @(negedge clk) begin
        if (rst_n) begin
            case (bus_cmd)
                3'd1: cnt_rd++;
                3'd2: cnt_rfo++;
                3'd3: cnt_upg++;
                3'd4: cnt_wb++;
                default: ;
            endcase
            if (rsp_valid) begin
                rsp_cyc = cyc;
                if (sb.size() == 0) begin
                    chk("R13 unexpected response", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk({e.rq, " data"}, rsp_data, e.data);
                    chk({e.rq, " fail"}, {31'd0, rsp_fail}, {31'd0, e.fail});
                    chk({e.rq, " bus rd/rfo/upg/wb"}, {cnt_rd, cnt_rfo, cnt_upg, cnt_wb}, e.bus);
                    chk("R13 ready low at response", {31'd0, req_ready}, 32'd0);
                end
                cnt_rd = 0; cnt_rfo = 0; cnt_upg = 0; cnt_wb = 0;
            end
        end
    end

    task automatic do_op(input string rq, input int op, input int a,
                         input logic [DW-1:0] wd, input logic [DW-1:0] cmp);
        int idx, tg;
        logic [7:0] nrd, nrfo, nupg, nwb;
        logic [DW-1:0] old;
        exp_t e;
        idx = a % NL; tg = a / NL;
        nrd = 0; nrfo = 0; nupg = 0; nwb = 0;
        if (!(m_st[idx] != 0 && m_tg[idx] == tg)) begin
            if (m_st[idx] == 3) begin
                nwb++;
                m_mem[m_tg[idx] * NL + idx] = m_dt[idx];
            end
            if (op == 0) begin nrd++; m_st[idx] = 1; end
            else         begin nrfo++; m_st[idx] = 2; end
            m_dt[idx] = m_mem[a];
            m_tg[idx] = tg;
        end else if (op != 0 && m_st[idx] == 1) begin
            nupg++;
            m_st[idx] = 2;
        end
        old = m_dt[idx];
        e.rq = rq; e.data = old; e.fail = 1'b0; e.bus = {nrd, nrfo, nupg, nwb};
        case (op)
            1: begin m_dt[idx] = wd; m_st[idx] = 3; e.data = '0; end
            2: begin
                if (old == cmp) begin m_dt[idx] = wd; m_st[idx] = 3; end
                else e.fail = 1'b1;
            end
            3: begin m_dt[idx] = old + wd; m_st[idx] = 3; end
            4: begin m_dt[idx] = old - 1; m_st[idx] = 3; end
            default: ;
        endcase
        sb.push_back(e);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = 3'(op); req_addr = AW'(a); req_wdata = wd; req_cmp = cmp;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R13 ready drops after accept", {31'd0, req_ready}, 32'd0);
        while (sb.size() != 0) @(negedge clk);
    endtask

    task automatic snoop(input string rq, input logic inv, input int a);
        int idx, tg;
        logic dirty_a;
        logic [DW-1:0] data_a, exp_d;
        logic exp_dirty;
        snp_valid = 1'b1; snp_inv = inv; snp_addr = AW'(a);
        forever begin
            #1;
            if (snp_ack) break;
            @(negedge clk);
        end
        dirty_a = snp_dirty; data_a = snp_data; ack_cyc = cyc;
        idx = a % NL; tg = a / NL;
        exp_dirty = 1'b0; exp_d = '0;
        if (m_st[idx] != 0 && m_tg[idx] == tg) begin
            if (m_st[idx] == 3) begin
                exp_dirty = 1'b1; exp_d = m_dt[idx];
                m_mem[a] = m_dt[idx];
            end
            m_st[idx] = inv ? 0 : 1;
        end
        chk({rq, " snoop dirty"}, {31'd0, dirty_a}, {31'd0, exp_dirty});
        chk({rq, " snoop data"}, data_a, exp_d);
        @(posedge clk);
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) m_mem[i] = 32'h1000_0000 + i * 257;
        for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_tg[i] = 0; m_dt[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", {31'd0, req_ready}, 32'd1);
        chk("R1 no response after reset", {31'd0, rsp_valid}, 32'd0);
        chk("R1 bus idle after reset", {29'd0, bus_cmd}, 32'd0);
        chk("R1 no snoop ack after reset", {31'd0, snp_ack}, 32'd0);

        do_op("R1 R2 load miss", 0, 'h10, 0, 0);
        do_op("R3 load hit shared", 0, 'h10, 0, 0);
        do_op("R4 store hit shared", 1, 'h10, 32'hCAFE_0001, 0);
        do_op("R3 load hit modified", 0, 'h10, 0, 0);
        do_op("R4 store miss", 1, 'h21, 32'hBEEF_0002, 0);
        do_op("R4 store hit modified", 1, 'h21, 32'hBEEF_0003, 0);
        do_op("R10 dirty victim", 0, 'h14, 0, 0);
        do_op("R10 clean victim", 0, 'h10, 0, 0);
        do_op("R5 R8 cas shared ok", 2, 'h10, 32'h0000_0777, 32'hCAFE_0001);
        do_op("R6 R8 cas modified fail", 2, 'h10, 32'h0000_0888, 32'h1234_5678);
        do_op("R7 R8 cas miss fail", 2, 'h32, 32'h0000_0999, 32'h0);
        snoop("R7 R11 exclusive clean", 1'b0, 'h32);
        do_op("R5 R9 add shared", 3, 'h32, 32'h0000_0010, 0);
        do_op("R6 R9 dec modified", 4, 'h32, 0, 0);
        snoop("R11 read modified", 1'b0, 'h32);
        do_op("R3 load after snoop", 0, 'h32, 0, 0);
        snoop("R11 inv modified", 1'b1, 'h21);
        do_op("R11 reload after inv", 0, 'h21, 0, 0);
        snoop("R11 miss", 1'b0, 'h99);
        do_op("R4 store exclusive path", 1, 'h43, 32'h0000_0043, 0);

        do_op("R5 R9 add upgrade", 3, 'h32, 32'h5, 0);
        fork
            do_op("R6 R12 locked add", 3, 'h32, 32'h7, 0);
            begin repeat (2) @(negedge clk); snoop("R12 same line", 1'b1, 'h32); end
        join
        chk("R12 same-line snoop after response", {31'd0, (ack_cyc >= rsp_cyc)}, 32'd1);

        fork
            do_op("R6 R12 locked add other", 3, 'h10, 32'h1, 0);
            begin repeat (2) @(negedge clk); snoop("R12 other line", 1'b0, 'h21); end
        join
        chk("R12 other-line snoop before response", {31'd0, (ack_cyc < rsp_cyc)}, 32'd1);

        fork
            do_op("R7 R12 atomic miss", 4, 'h32, 0, 0);
            begin repeat (2) @(negedge clk); snoop("R12 during bus", 1'b0, 'h10); end
        join
        do_op("R10 R3 final load", 0, 'h10, 0, 0);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait (cyc > 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule